// File: doc/BRIEF.md
# Block Memory Move Engine

The engine copies a run of bytes from one banked region of a 24-bit address space to another. A bank byte sits above a 16-bit index to form each address. Software-visible state is a 16-bit count that holds the number of bytes minus one, plus a source index and a destination index. A start pulse latches these values together with a source bank, a destination bank, a direction and an index-width mode. The engine then runs one byte per step until the count wraps past zero.

Each step reads one byte through a byte-wide memory port and writes it back through the same port. Both accesses use a request/ready handshake. Two internal cycles follow each write, which leaves a clean step boundary. The updated count and indices are driven on outputs all the time. The destination bank is driven as the data bank value. A one-cycle done pulse marks the end of the move.

Top module: `blk_move_engine`

## Requirements
- R1: Every read access presents the address {source bank, source index} with write-enable low.
- R2: Every write access presents the address {destination bank, destination index}, with write data equal to the byte returned by the step's read.
- R3: An accepted start loads the data bank output with the destination bank. The value is visible in the cycle after the start.
- R4: In ascending mode (desc_i=0) both indices increase by one after each byte. In descending mode (desc_i=1) both decrease by one. In full-width mode they wrap modulo 2^16.
- R5: The count decreases by one after each byte written. The move ends when the count reaches 0xFFFF, so a start count of N moves N+1 bytes.
- R6: In narrow mode (narrow_i=1) only the low 8 bits of each index step and wrap. The high 8 bits keep the values they had at start.
- R7: A step is one read access, one write access, then exactly two cycles with no request. With zero wait states a move of S bytes keeps busy high for 4*S cycles.
- R8: A start pulse while busy is high is ignored. The move in progress and its results are unchanged.
- R9: done_o is high for exactly one cycle after the final step's internal cycles. busy_o is low in that cycle.
- R10: While a request is pending and ready is low, address, write-enable and write data stay stable.
- R11: After reset the engine is idle. It makes no request, done is low, and the count, index and bank outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| desc_i | input | 1 | 1 = descending indices, 0 = ascending |
| narrow_i | input | 1 | 1 = 8-bit index stepping |
| dst_bank_i | input | 8 | Destination bank |
| src_bank_i | input | 8 | Source bank |
| cnt_i | input | 16 | Byte count minus one |
| src_idx_i | input | 16 | Initial source index |
| dst_idx_i | input | 16 | Initial destination index |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write access |
| mem_addr_o | output | 24 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access accepted at this edge |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle end-of-move pulse |
| cnt_o | output | 16 | Current count |
| src_idx_o | output | 16 | Current source index |
| dst_idx_o | output | 16 | Current destination index |
| dbank_o | output | 8 | Data bank (destination bank) |

## Verification
The bench uses the default parameters: 8-bit banks, 16-bit indices, an 8-bit narrow width and two internal cycles per step. With these values, short moves reach both the 0xFF low-byte wrap of narrow mode and the 0x0000/0xFFFF full-width wrap. The bench runs moves with zero and nonzero wait states. This exposes the per-step cycle cost and keeps the port holding a request across ready-low cycles. A second start fired in the middle of a move checks that a busy engine ignores it.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_INT  = 2'd3
  } mv_state_e;
endpackage

// File: rtl/blkmv_idx_step.sv
module blkmv_idx_step #(
  parameter int IDX_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             desc_i,
  input  logic             narrow_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0]    full_nxt;
  logic [NARROW_W-1:0] low_nxt;

  assign full_nxt = desc_i ? idx_i - 1'b1 : idx_i + 1'b1;
  assign low_nxt  = desc_i ? idx_i[NARROW_W-1:0] - 1'b1 : idx_i[NARROW_W-1:0] + 1'b1;

  generate
    if (NARROW_W < IDX_W) begin : g_split
      assign idx_o = narrow_i ? {idx_i[IDX_W-1:NARROW_W], low_nxt} : full_nxt;
    end else begin : g_same
      logic unused_narrow;
      assign unused_narrow = narrow_i ^ (|low_nxt);
      assign idx_o = full_nxt;
    end
  endgenerate
endmodule

// File: rtl/blkmv_seq.sv
module blkmv_seq
  import blkmv_pkg::*;
#(
  parameter int INT_CYC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      rdy_i,
  input  logic      last_i,
  output mv_state_e state_o,
  output logic      load_o,
  output logic      rd_take_o,
  output logic      wr_take_o,
  output logic      done_o
);
  localparam int IC_W = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;

  mv_state_e        state_q, state_d;
  logic [IC_W-1:0]  icnt_q;
  logic             icnt_end;
  logic             done_q;

  assign icnt_end  = (icnt_q == IC_W'(INT_CYC - 1));
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign rd_take_o = (state_q == ST_RD) && rdy_i;
  assign wr_take_o = (state_q == ST_WR) && rdy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)   state_d = ST_RD;
      ST_RD:   if (rdy_i)     state_d = ST_WR;
      ST_WR:   if (rdy_i)     state_d = ST_INT;
      ST_INT:  if (icnt_end)  state_d = last_i ? ST_IDLE : ST_RD;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      icnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      icnt_q  <= (state_q == ST_INT && !icnt_end) ? icnt_q + 1'b1 : '0;
      done_q  <= (state_q == ST_INT) && icnt_end && last_i;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/blk_move_engine.sv
module blk_move_engine
  import blkmv_pkg::*;
#(
  parameter int BANK_W   = 8,
  parameter int IDX_W    = 16,
  parameter int NARROW_W = 8,
  parameter int DATA_W   = 8,
  parameter int INT_CYC  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    desc_i,
  input  logic                    narrow_i,
  input  logic [BANK_W-1:0]       dst_bank_i,
  input  logic [BANK_W-1:0]       src_bank_i,
  input  logic [IDX_W-1:0]        cnt_i,
  input  logic [IDX_W-1:0]        src_idx_i,
  input  logic [IDX_W-1:0]        dst_idx_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [BANK_W+IDX_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  input  logic                    mem_rdy_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [IDX_W-1:0]        cnt_o,
  output logic [IDX_W-1:0]        src_idx_o,
  output logic [IDX_W-1:0]        dst_idx_o,
  output logic [BANK_W-1:0]       dbank_o
);
  mv_state_e         state;
  logic              load, rd_take, wr_take, last;
  logic [IDX_W-1:0]  cnt_q, src_idx_q, dst_idx_q;
  logic [IDX_W-1:0]  src_idx_nxt, dst_idx_nxt;
  logic [BANK_W-1:0] src_bank_q, dbank_q;
  logic [DATA_W-1:0] data_q;
  logic              desc_q, narrow_q;

  // count is already decremented when the internal cycles run
  assign last = (cnt_q == '1);

  blkmv_seq #(.INT_CYC(INT_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .rdy_i     (mem_rdy_i),
    .last_i    (last),
    .state_o   (state),
    .load_o    (load),
    .rd_take_o (rd_take),
    .wr_take_o (wr_take),
    .done_o    (done_o)
  );

  blkmv_idx_step #(.IDX_W(IDX_W), .NARROW_W(NARROW_W)) u_src_step (
    .idx_i    (src_idx_q),
    .desc_i   (desc_q),
    .narrow_i (narrow_q),
    .idx_o    (src_idx_nxt)
  );

  blkmv_idx_step #(.IDX_W(IDX_W), .NARROW_W(NARROW_W)) u_dst_step (
    .idx_i    (dst_idx_q),
    .desc_i   (desc_q),
    .narrow_i (narrow_q),
    .idx_o    (dst_idx_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      src_idx_q  <= '0;
      dst_idx_q  <= '0;
      src_bank_q <= '0;
      dbank_q    <= '0;
      data_q     <= '0;
      desc_q     <= 1'b0;
      narrow_q   <= 1'b0;
    end else if (load) begin
      cnt_q      <= cnt_i;
      src_idx_q  <= src_idx_i;
      dst_idx_q  <= dst_idx_i;
      src_bank_q <= src_bank_i;
      dbank_q    <= dst_bank_i;
      desc_q     <= desc_i;
      narrow_q   <= narrow_i;
    end else if (rd_take) begin
      data_q     <= mem_rdata_i;
    end else if (wr_take) begin
      cnt_q      <= cnt_q - 1'b1;
      src_idx_q  <= src_idx_nxt;
      dst_idx_q  <= dst_idx_nxt;
    end
  end

  // port driven from state and registers only: stable while waiting on ready
  assign mem_req_o   = (state == ST_RD) || (state == ST_WR);
  assign mem_we_o    = (state == ST_WR);
  assign mem_addr_o  = (state == ST_RD) ? {src_bank_q, src_idx_q} : {dbank_q, dst_idx_q};
  assign mem_wdata_o = data_q;

  assign busy_o    = (state != ST_IDLE);
  assign cnt_o     = cnt_q;
  assign src_idx_o = src_idx_q;
  assign dst_idx_o = dst_idx_q;
  assign dbank_o   = dbank_q;
endmodule

// File: rtl/blkmv_chk.sv
module blkmv_chk #(
  parameter int BANK_W = 8,
  parameter int IDX_W  = 16,
  parameter int DATA_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    mem_req_o,
  input logic                    mem_we_o,
  input logic [BANK_W+IDX_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0]       mem_wdata_o,
  input logic                    mem_rdy_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [IDX_W-1:0]        cnt_o,
  input logic [IDX_W-1:0]        src_idx_o,
  input logic [IDX_W-1:0]        dst_idx_o,
  input logic [BANK_W-1:0]       dbank_o
);
  assert_rd_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o[IDX_W-1:0] == src_idx_o));

  assert_wr_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == {dbank_o, dst_idx_o}));

  assert_cnt_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_rdy_i) |=> (cnt_o == $past(cnt_o) - 1'b1));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(dbank_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_port_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

bind blk_move_engine blkmv_chk #(
  .BANK_W (BANK_W),
  .IDX_W  (IDX_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdy_i   (mem_rdy_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cnt_o       (cnt_o),
  .src_idx_o   (src_idx_o),
  .dst_idx_o   (dst_idx_o),
  .dbank_o     (dbank_o)
);

// File: tb/test_blk_move_engine.sv
module test_blk_move_engine;
  localparam int CLK_PERIOD = 10;
  localparam int INT_CYC    = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        desc_i = 1'b0;
  logic        narrow_i = 1'b0;
  logic [7:0]  dst_bank_i = '0;
  logic [7:0]  src_bank_i = '0;
  logic [15:0] cnt_i = '0;
  logic [15:0] src_idx_i = '0;
  logic [15:0] dst_idx_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_rdy_i = 1'b0;
  logic        busy_o, done_o;
  logic [15:0] cnt_o, src_idx_o, dst_idx_o;
  logic [7:0]  dbank_o;

  int checks = 0;
  int fails  = 0;
  int waits  = 0;
  int wcnt   = 0;
  int rd_n   = 0;
  int wr_n   = 0;
  logic [7:0] mem [int unsigned];

  blk_move_engine #(.INT_CYC(INT_CYC)) i_blk_move_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .desc_i(desc_i),
    .narrow_i(narrow_i), .dst_bank_i(dst_bank_i), .src_bank_i(src_bank_i),
    .cnt_i(cnt_i), .src_idx_i(src_idx_i), .dst_idx_i(dst_idx_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
    .busy_o(busy_o), .done_o(done_o), .cnt_o(cnt_o), .src_idx_o(src_idx_o),
    .dst_idx_o(dst_idx_o), .dbank_o(dbank_o)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // memory responder: decides ready at the falling edge
  initial forever begin
    @(negedge clk);
    if (mem_req_o) begin
      if (wcnt == 0) begin
        mem_rdy_i = 1'b1;
        if (mem_we_o) begin
          mem[int'(mem_addr_o)] = mem_wdata_o;
          wr_n++;
        end else begin
          mem_rdata_i = mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 8'h00;
          rd_n++;
        end
        wcnt = waits;
      end else begin
        mem_rdy_i = 1'b0;
        wcnt--;
      end
    end else begin
      mem_rdy_i = 1'b0;
      wcnt = waits;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] stepi(input logic [15:0] i, input bit d, input bit n);
    logic [15:0] f;
    f = d ? i - 16'd1 : i + 16'd1;
    return n ? {i[15:8], f[7:0]} : f;
  endfunction

  task automatic run_move(input string tag, input logic [7:0] db, input logic [7:0] sb,
                          input logic [15:0] si, input logic [15:0] di, input logic [15:0] c,
                          input bit d, input bit n, input int w, input bit poke);
    logic [15:0] s, t;
    int steps, cyc, guard;
    steps = int'(c) + 1;
    s = si; t = di;
    for (int k = 0; k < steps; k++) begin
      mem[int'({sb, s})] = pat({sb, s});
      mem[int'({db, t})] = 8'h00;
      s = stepi(s, d, n); t = stepi(t, d, n);
    end
    waits = w; rd_n = 0; wr_n = 0;
    @(negedge clk);
    dst_bank_i = db; src_bank_i = sb; src_idx_i = si; dst_idx_i = di;
    cnt_i = c; desc_i = d; narrow_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {tag, " R9 busy after start"}, busy_o, 1);
    chk(dbank_o == db, {tag, " R3 data bank"}, dbank_o, db);
    cyc = 1; guard = 0;
    while (!done_o && guard < 20000) begin
      @(negedge clk);
      if (poke && cyc == 5) begin
        // R8: second start mid-move with other values
        dst_bank_i = 8'hEE; src_bank_i = 8'hDD; src_idx_i = 16'h0000;
        dst_idx_i = 16'h0000; cnt_i = 16'h0010; desc_i = ~d; start_i = 1'b1;
      end else start_i = 1'b0;
      if (busy_o) cyc++;
      guard++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, {tag, " R9 done seen"}, done_o, 1);
    chk(busy_o == 1'b0, {tag, " R9 idle with done"}, busy_o, 0);
    chk(cyc == steps * (2 * (w + 1) + INT_CYC), {tag, " R7 busy cycles"}, cyc,
        steps * (2 * (w + 1) + INT_CYC));
    chk(rd_n == steps && wr_n == steps, {tag, " R7 one read one write per byte"}, wr_n, steps);
    chk(cnt_o == 16'hFFFF, {tag, " R5 final count"}, cnt_o, 16'hFFFF);
    chk(src_idx_o == s, {tag, n ? " R6 src index" : " R4 src index"}, src_idx_o, s);
    chk(dst_idx_o == t, {tag, n ? " R6 dst index" : " R4 dst index"}, dst_idx_o, t);
    chk(dbank_o == db, {tag, " R8 bank kept"}, dbank_o, db);
    s = si; t = di;
    for (int k = 0; k < steps; k++) begin
      chk(mem[int'({db, t})] == pat({sb, s}), {tag, " R1 R2 copied byte"},
          mem[int'({db, t})], pat({sb, s}));
      s = stepi(s, d, n); t = stepi(t, d, n);
    end
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R9 done one cycle"}, done_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy_o == 1'b0 && mem_req_o == 1'b0, "R11 idle after reset", {busy_o, mem_req_o}, 0);
    chk(done_o == 1'b0, "R11 done low", done_o, 0);
    chk(cnt_o == 0 && src_idx_o == 0 && dst_idx_o == 0, "R11 regs zero", cnt_o, 0);
    chk(dbank_o == 0, "R11 bank zero", dbank_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    run_move("asc16",   8'h02, 8'h01, 16'h1000, 16'h2000, 16'd3, 1'b0, 1'b0, 0, 1'b0);
    run_move("desc16",  8'h04, 8'h03, 16'h3005, 16'h4005, 16'd2, 1'b1, 1'b0, 2, 1'b0);
    run_move("narrow",  8'h06, 8'h05, 16'h12FE, 16'h34FF, 16'd2, 1'b0, 1'b1, 1, 1'b0);
    run_move("narrowd", 8'h08, 8'h07, 16'h5601, 16'h7800, 16'd2, 1'b1, 1'b1, 0, 1'b0);
    run_move("wrap16",  8'h0A, 8'h09, 16'h0001, 16'hFFFF, 16'd2, 1'b1, 1'b0, 0, 1'b0);
    run_move("single",  8'h0C, 8'h0B, 16'h00FF, 16'h0100, 16'd0, 1'b0, 1'b0, 3, 1'b0);
    run_move("busy",    8'h0E, 8'h0D, 16'h2222, 16'h3333, 16'd3, 1'b0, 1'b0, 1, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule